// File: doc/BRIEF.md
# Multi-mode programmable delay timer

This block produces a programmed time delay on one active-low output. An 8-bit weighted value gives the delay as a number of timebase ticks. A trigger input starts the delay. A two-bit mode input picks how the output follows the trigger edges: one-shot, delayed operate, delayed release or dual delay. A synchronous reset aborts any delay in progress.

The trigger passes through a two-flop synchronizer and an edge detector. The edges drive a state machine, which loads a single down-counter. The counter decrements on ticks from a prescaler. The prescaler either passes every clock cycle or divides the clock by one of two ratios, one for mains-rate delays and one for watch-crystal-rate delays. The divider restarts every time the counter is loaded, so a programmed value N with ratio D always lasts exactly N*D clock cycles.

States: IDLE (output high). OS_RUN (one-shot timing, output low). DO_WAIT (operate delay, output high). DO_ON (operated, output low). DR_HOLD (trigger held, output low). DR_RUN (release delay, output low). DD_RISE (dual delay on the rising edge, output high). DD_ON (dual delay operated, output low). DD_FALL (dual delay on the falling edge, output low).

Transitions:
- IDLE goes to OS_RUN, DO_WAIT, DR_HOLD or DD_RISE on a rising edge, according to the mode.
- OS_RUN restarts itself on a rising edge and goes to IDLE on expiry.
- DO_WAIT goes to IDLE on a falling edge and to DO_ON on expiry.
- DO_ON goes to IDLE on a falling edge.
- DR_HOLD goes to DR_RUN on a falling edge.
- DR_RUN goes back to DR_HOLD on a rising edge and to IDLE on expiry.
- DD_RISE goes to IDLE on a falling edge and to DD_ON on expiry.
- DD_ON goes to DD_FALL on a falling edge.
- DD_FALL goes back to DD_ON on a rising edge and to IDLE on expiry.

Top module: `prog_delay_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the state returns to IDLE, the counter clears and `out_n` is high after that edge. A delay in progress is abandoned and does not resume after reset is released.
- R2: `mode_sel` encodes 2'b00 one-shot, 2'b01 delayed operate, 2'b10 delayed release and 2'b11 dual delay.
- R3: Timing of edges and expiry:
  - A trigger change that is set up before a clock edge is acted on at the third rising edge, and `out_n` changes after that edge.
  - A delay loaded at edge S expires at edge S + N*D.
  - In one-shot mode, a rising edge drives `out_n` low and starts the delay. Expiry drives `out_n` high.
- R4: In one-shot mode, a rising edge while the delay runs reloads the full value.
- R5: In one-shot mode, a falling edge of the trigger has no effect.
- R6: In delayed operate mode, a rising edge starts the delay with `out_n` high. Expiry drives `out_n` low. A later falling edge drives `out_n` high.
- R7: In delayed operate mode, a falling edge before expiry cancels the delay, and `out_n` stays high.
- R8: In delayed release mode, a rising edge drives `out_n` low. A falling edge starts the delay, and expiry drives `out_n` high.
- R9: In delayed release mode, a rising edge during the release delay cancels it, and `out_n` stays low.
- R10: In dual delay mode:
  - A rising edge drives `out_n` low one delay later.
  - A later falling edge drives `out_n` high one delay later.
  - A falling edge during the rising-edge delay cancels it.
  - A rising edge during the falling-edge delay cancels it.
- R11: A programmed value of 0 acts as a delay of one tick.
- R12: `tick_sel` sets the tick ratio D: 2'b00 and 2'b11 give D = 1, 2'b01 gives D = MAINS_DIV and 2'b10 gives D = XTAL_DIV.
- R13: `mode_sel` is used only in IDLE. Changing it during a delay does not alter that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset and abort, active high |
| trig_in | input | 1 | Asynchronous trigger |
| mode_sel | input | 2 | Output mode |
| tick_sel | input | 2 | Timebase ratio select |
| delay_val | input | DLY_W | Programmed delay in ticks |
| out_n | output | 1 | Delay output, active low |

## Verification
The output is a pure decode of the state, so a wrong state shows on `out_n` at once, with two exceptions. DO_WAIT and DD_RISE drive the output high, exactly as IDLE does. A wrong move between these three states stays hidden until the delay expires, or fails to expire, N*D cycles later. A counter loaded with the wrong value, or a prescaler that does not restart on load, moves the output edge by whole ticks. The bench therefore samples the cycle just before and the cycle just after every expected output change.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_DLY_ON   = 2'b01,
        MODE_DLY_OFF  = 2'b10,
        MODE_DUAL     = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        TB_RAW     = 2'b00,
        TB_MAINS   = 2'b01,
        TB_XTAL    = 2'b10,
        TB_RAW_ALT = 2'b11
    } tbase_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OS_RUN,
        ST_DO_WAIT,
        ST_DO_ON,
        ST_DR_HOLD,
        ST_DR_RUN,
        ST_DD_RISE,
        ST_DD_ON,
        ST_DD_FALL
    } state_e;

endpackage

// File: rtl/pdt_edge_sync.sv
module pdt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic rise,
    output logic fall
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], trig_in};
    end

    assign rise =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];
endmodule

// File: rtl/pdt_tick_gen.sv
module pdt_tick_gen
    import pdt_pkg::*;
#(
    parameter int MAINS_DIV = 60,
    parameter int XTAL_DIV  = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAXDIV = (MAINS_DIV > XTAL_DIV) ? MAINS_DIV : XTAL_DIV;
    localparam int CW     = $clog2(MAXDIV + 1);

    logic [CW-1:0] ratio;
    logic [CW-1:0] div_q;

    always_comb begin
        unique case (tbase_e'(sel))
            TB_MAINS: ratio = CW'(MAINS_DIV);
            TB_XTAL:  ratio = CW'(XTAL_DIV);
            default:  ratio = CW'(1);
        endcase
    end

    assign tick = (div_q == ratio - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || tick) div_q <= '0;
        else                        div_q <= div_q + CW'(1);
    end
endmodule

// File: rtl/pdt_down_counter.sv
module pdt_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         done,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (load_val == '0) ? W'(1) : load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign done  = tick && (cnt_q == W'(1));
    assign count = cnt_q;
endmodule

// File: rtl/prog_delay_timer.sv
module prog_delay_timer
    import pdt_pkg::*;
#(
    parameter int DLY_W     = 8,
    parameter int MAINS_DIV = 60,
    parameter int XTAL_DIV  = 32768
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       tick_sel,
    input  logic [DLY_W-1:0] delay_val,
    output logic             out_n
);
    state_e             state_q, state_d;
    logic               trig_rise, trig_fall;
    logic               cnt_load, cnt_clear, cnt_done, tick;
    logic [DLY_W-1:0]   cnt_val;

    pdt_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .rise(trig_rise), .fall(trig_fall)
    );

    pdt_tick_gen #(.MAINS_DIV(MAINS_DIV), .XTAL_DIV(XTAL_DIV)) u_tick (
        .clk(clk), .rst(rst), .restart(cnt_load), .sel(tick_sel), .tick(tick)
    );

    pdt_down_counter #(.W(DLY_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .clear(cnt_clear),
        .load_val(delay_val), .tick(tick), .done(cnt_done), .count(cnt_val)
    );

    // next state, counter control
    always_comb begin
        state_d   = state_q;
        cnt_load  = 1'b0;
        cnt_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_rise) begin
                    unique case (mode_e'(mode_sel))
                        MODE_ONESHOT: begin state_d = ST_OS_RUN;  cnt_load = 1'b1; end
                        MODE_DLY_ON:  begin state_d = ST_DO_WAIT; cnt_load = 1'b1; end
                        MODE_DLY_OFF: begin state_d = ST_DR_HOLD; end
                        MODE_DUAL:    begin state_d = ST_DD_RISE; cnt_load = 1'b1; end
                    endcase
                end
            end
            ST_OS_RUN: begin
                if (trig_rise)     begin cnt_load = 1'b1; end
                else if (cnt_done) begin state_d = ST_IDLE; end
            end
            ST_DO_WAIT: begin
                if (trig_fall)     begin state_d = ST_IDLE; cnt_clear = 1'b1; end
                else if (cnt_done) begin state_d = ST_DO_ON; end
            end
            ST_DO_ON: begin
                if (trig_fall) state_d = ST_IDLE;
            end
            ST_DR_HOLD: begin
                if (trig_fall) begin state_d = ST_DR_RUN; cnt_load = 1'b1; end
            end
            ST_DR_RUN: begin
                if (trig_rise)     begin state_d = ST_DR_HOLD; cnt_clear = 1'b1; end
                else if (cnt_done) begin state_d = ST_IDLE; end
            end
            ST_DD_RISE: begin
                if (trig_fall)     begin state_d = ST_IDLE; cnt_clear = 1'b1; end
                else if (cnt_done) begin state_d = ST_DD_ON; end
            end
            ST_DD_ON: begin
                if (trig_fall) begin state_d = ST_DD_FALL; cnt_load = 1'b1; end
            end
            ST_DD_FALL: begin
                if (trig_rise)     begin state_d = ST_DD_ON; cnt_clear = 1'b1; end
                else if (cnt_done) begin state_d = ST_IDLE; end
            end
            default: begin state_d = ST_IDLE; cnt_clear = 1'b1; end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_OS_RUN, ST_DO_ON, ST_DR_HOLD,
            ST_DR_RUN, ST_DD_ON, ST_DD_FALL: out_n = 1'b0;
            default:                         out_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/pdt_chk.sv
module pdt_chk
    import pdt_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode_sel,
    input logic         out_n,
    input state_e       state,
    input logic         rise,
    input logic         fall,
    input logic         done,
    input logic         load,
    input logic [W-1:0] count
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (out_n && state == ST_IDLE && count == '0));

    // R3
    os_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && rise && mode_sel == 2'b00) |=> !out_n);

    // R5
    os_fall_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OS_RUN && fall && !done) |=> (state == ST_OS_RUN));

    // R7
    do_fall_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DO_WAIT || state == ST_DO_ON) && fall) |=> out_n);

    // R9
    dr_rise_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DR_RUN && rise) |=> (state == ST_DR_HOLD && !out_n));

    // R11
    load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count != '0));

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}));
endmodule

bind prog_delay_timer pdt_chk #(.W(DLY_W)) u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .out_n(out_n),
    .state(state_q), .rise(trig_rise), .fall(trig_fall),
    .done(cnt_done), .load(cnt_load), .count(cnt_val)
);

// File: tb/test_prog_delay_timer.sv
module test_prog_delay_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_in = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] tick_sel = 2'b00;
    logic [7:0] delay_val = 8'd1;
    logic       out_n;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    prog_delay_timer #(.DLY_W(8), .MAINS_DIV(5), .XTAL_DIV(8)) i_prog_delay_timer (
        .clk(clk), .rst(rst), .trig_in(trig_in), .mode_sel(mode_sel),
        .tick_sel(tick_sel), .delay_val(delay_val), .out_n(out_n)
    );

    always #2 clk = ~clk;

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req, input string what);
        checks++;
        if (out_n !== exp) begin
            errors++;
            $display("FAIL %s %s: out_n=%0b expected %0b", req, what, out_n, exp);
        end
    endtask

    task automatic settle();
        trig_in = 1'b0;
        wait_cyc(30);
        mode_sel = 2'b00;
        tick_sel = 2'b00;
    endtask

    task automatic t_reset_state();
        wait_cyc(3);
        check(1'b1, "R1", "during reset");
        rst = 1'b0;
        wait_cyc(3);
        check(1'b1, "R1", "after reset release");
    endtask

    task automatic t_os_basic();
        mode_sel = 2'b00; delay_val = 8'd5;
        trig_in = 1'b1;
        wait_cyc(2); check(1'b1, "R3", "before third edge");
        wait_cyc(1); check(1'b0, "R2", "one-shot low at third edge");
        wait_cyc(4); check(1'b0, "R3", "edge 7 still low");
        wait_cyc(1); check(1'b1, "R3", "edge 8 expired");
        settle();
    endtask

    task automatic t_os_fall();
        mode_sel = 2'b00; delay_val = 8'd4;
        trig_in = 1'b1;
        wait_cyc(3); trig_in = 1'b0;
        wait_cyc(3); check(1'b0, "R5", "fall ignored, still low");
        wait_cyc(1); check(1'b1, "R5", "expiry unchanged by fall");
        settle();
    endtask

    task automatic t_os_retrig();
        mode_sel = 2'b00; delay_val = 8'd6;
        trig_in = 1'b1;
        wait_cyc(3); trig_in = 1'b0;
        wait_cyc(2); trig_in = 1'b1;
        wait_cyc(4); check(1'b0, "R4", "no expiry at original time");
        wait_cyc(4); check(1'b0, "R4", "edge 13 low");
        wait_cyc(1); check(1'b1, "R4", "restarted delay expired");
        settle();
    endtask

    task automatic t_do_basic();
        mode_sel = 2'b01; delay_val = 8'd4;
        trig_in = 1'b1;
        wait_cyc(6); check(1'b1, "R6", "high during operate delay");
        wait_cyc(1); check(1'b0, "R6", "low at expiry");
        wait_cyc(3); trig_in = 1'b0;
        wait_cyc(2); check(1'b0, "R6", "low before fall acts");
        wait_cyc(1); check(1'b1, "R6", "released on fall");
        settle();
    endtask

    task automatic t_do_cancel();
        mode_sel = 2'b01; delay_val = 8'd10;
        trig_in = 1'b1;
        wait_cyc(4); trig_in = 1'b0;
        wait_cyc(10); check(1'b1, "R7", "cancelled, edge 14");
        wait_cyc(6);  check(1'b1, "R7", "cancelled, edge 20");
        settle();
    endtask

    task automatic t_dr_basic();
        mode_sel = 2'b10; delay_val = 8'd5;
        trig_in = 1'b1;
        wait_cyc(3); check(1'b0, "R8", "low on rise");
        wait_cyc(3); trig_in = 1'b0;
        wait_cyc(7); check(1'b0, "R8", "low during release delay");
        wait_cyc(1); check(1'b1, "R8", "high at release expiry");
        settle();
    endtask

    task automatic t_dr_cancel();
        mode_sel = 2'b10; delay_val = 8'd6;
        trig_in = 1'b1;
        wait_cyc(6); trig_in = 1'b0;
        wait_cyc(3); trig_in = 1'b1;
        wait_cyc(6); check(1'b0, "R9", "no expiry after re-rise");
        wait_cyc(6); check(1'b0, "R9", "still held low");
        trig_in = 1'b0;
        wait_cyc(8); check(1'b0, "R9", "new release delay running");
        wait_cyc(1); check(1'b1, "R9", "new release delay expired");
        settle();
    endtask

    task automatic t_dd();
        mode_sel = 2'b11; delay_val = 8'd4;
        trig_in = 1'b1;
        wait_cyc(6); check(1'b1, "R10", "high during rise delay");
        wait_cyc(1); check(1'b0, "R10", "low after rise delay");
        wait_cyc(3); trig_in = 1'b0;
        wait_cyc(6); check(1'b0, "R10", "low during fall delay");
        wait_cyc(1); check(1'b1, "R10", "high after fall delay");
        settle();
        mode_sel = 2'b11; delay_val = 8'd8;
        trig_in = 1'b1;
        wait_cyc(4); trig_in = 1'b0;
        wait_cyc(20); check(1'b1, "R10", "rise delay cancelled by fall");
        settle();
    endtask

    task automatic t_zero();
        mode_sel = 2'b00; delay_val = 8'd0;
        trig_in = 1'b1;
        wait_cyc(3); check(1'b0, "R11", "low for one tick");
        wait_cyc(1); check(1'b1, "R11", "zero value is one tick");
        settle();
    endtask

    task automatic t_prescale();
        mode_sel = 2'b00; tick_sel = 2'b01; delay_val = 8'd3;
        trig_in = 1'b1;
        wait_cyc(17); check(1'b0, "R12", "mains ratio edge 17");
        wait_cyc(1);  check(1'b1, "R12", "mains ratio edge 18");
        settle();
        tick_sel = 2'b10; delay_val = 8'd2;
        trig_in = 1'b1;
        wait_cyc(18); check(1'b0, "R12", "crystal ratio edge 18");
        wait_cyc(1);  check(1'b1, "R12", "crystal ratio edge 19");
        settle();
        tick_sel = 2'b11; delay_val = 8'd3;
        trig_in = 1'b1;
        wait_cyc(5); check(1'b0, "R12", "raw alt edge 5");
        wait_cyc(1); check(1'b1, "R12", "raw alt edge 6");
        settle();
    endtask

    task automatic t_mode_idle();
        mode_sel = 2'b00; delay_val = 8'd8;
        trig_in = 1'b1;
        wait_cyc(4); mode_sel = 2'b01;
        wait_cyc(6); check(1'b0, "R13", "one-shot kept after mode change");
        wait_cyc(1); check(1'b1, "R13", "one-shot expiry kept");
        settle();
    endtask

    task automatic t_abort();
        mode_sel = 2'b00; delay_val = 8'd20;
        trig_in = 1'b1;
        wait_cyc(5); check(1'b0, "R1", "running before abort");
        rst = 1'b1; trig_in = 1'b0;
        wait_cyc(1); check(1'b1, "R1", "abort forces high");
        rst = 1'b0;
        wait_cyc(25); check(1'b1, "R1", "no resumed delay");
        settle();
    endtask

    initial begin
        t_reset_state();
        t_os_basic();
        t_os_fall();
        t_os_retrig();
        t_do_basic();
        t_do_cancel();
        t_dr_basic();
        t_dr_cancel();
        t_dd();
        t_zero();
        t_prescale();
        t_mode_idle();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule